// File: doc/BRIEF.md
# Bidirectional Serial-to-Parallel Latched Driver

This block converts a serial bit stream into a wide vector of channel-on signals for an array of print-head drivers. Bits enter a chain of stages whenever the shift clock falls. The shift clock is treated as a slow strobe and sampled on the fast system clock. A direction input picks which end of the chain takes the new bit, and it may change between shifts. A serial output shows whichever stage is currently last, so several blocks can be chained.

A latch bank sits behind the chain. While its enable is high it follows the chain, and while the enable is low it holds. An output enable either passes the latched bits to the channel outputs or forces every channel off. The latch contents survive while the output enable is low. The serial output and the channel vector are registered.

Top module: `sp_latched_driver`

## Requirements
- R1: A synchronous active-high `rst` clears the chain, the latches, `chan_on` and `sdata_out` to zero.
- R2: The chain moves one position only at the first `clk` edge where `sclk` is sampled low after being sampled high in the previous cycle. A rising `sclk` or a steady level never moves it.
- R3: With `dir` = 1, stage i passes its bit to stage i+1 and `sdata_in` enters stage 0. Stage i maps to `chan_on[i]`.
- R4: With `dir` = 0, stage i passes its bit to stage i-1 and `sdata_in` enters stage NUM_CH-1.
- R5: `sdata_out` shows stage NUM_CH-1 when `dir` = 1 and stage 0 when `dir` = 0. It is updated at the same edge as the chain, and it follows a change of `dir` at the next `clk` edge.
- R6: Neither `le` nor `oe` changes how or when the chain shifts.
- R7: At each `clk` edge with `le` = 1, the latches take the chain contents as they were before that edge. A shift therefore reaches the latches one edge later.
- R8: At each `clk` edge with `le` = 0, the latches keep their value.
- R9: At a `clk` edge with `oe` = 0, `chan_on` becomes all zero. The latch contents are left intact.
- R10: At a `clk` edge with `oe` = 1, `chan_on[i]` becomes the value latch bit i holds after that edge. A 1 means the channel is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Shift clock, sampled; a falling transition moves the chain |
| sdata_in | input | 1 | Serial data bit, sampled with the falling shift clock |
| dir | input | 1 | Shift direction: 1 toward higher stages, 0 toward lower |
| le | input | 1 | Latch enable: 1 follows the chain, 0 holds |
| oe | input | 1 | Output enable: 0 forces all channels off |
| sdata_out | output | 1 | Cascade output, last stage in the current direction |
| chan_on | output | NUM_CH | Channel-on vector, bit i for channel i |

## Verification
The chain contents are visible at the ports in only two ways: through the one-bit cascade output, or by copying them into the latches with both enables high. This makes it hard to show that a load with the latch closed and the outputs disabled left every stage and latch bit correct. The bench uses a small chain and loads every possible pattern in both directions. It checks the cascade bit after each shift and checks that the channels keep their old value during the load. It then opens the latch while the outputs are disabled, and only after that enables the outputs, to read back the whole pattern. At the end of each load it flips the direction once, so the opposite end is seen on the cascade output.

// File: rtl/sp_drv_pkg.sv
package sp_drv_pkg;
  typedef enum logic {
    SHIFT_DOWN = 1'b0,
    SHIFT_UP   = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/sp_edge_strobe.sv
module sp_edge_strobe (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic fall_stb
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_in;
  end

  assign fall_stb = level_q & ~level_in;

  AST_RISE_NO_STB: assert property (@(posedge clk) disable iff (rst)
    (!level_q && level_in) |-> !fall_stb); // R2
endmodule

// File: rtl/sp_shift_chain.sv
module sp_shift_chain
  import sp_drv_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  shift_dir_e       dir,
  input  logic             din,
  output logic [DEPTH-1:0] q,
  output logic [DEPTH-1:0] q_next
);
  localparam int TOP = DEPTH - 1;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic from_low, from_high;
    if (i == 0) begin : g_low_end
      assign from_low = din;
    end else begin : g_low_mid
      assign from_low = q[i-1];
    end
    if (i == TOP) begin : g_high_end
      assign from_high = din;
    end else begin : g_high_mid
      assign from_high = q[i+1];
    end
    assign q_next[i] = !stb ? q[i] : (dir == SHIFT_UP ? from_low : from_high);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(q)); // R2
  AST_UP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (stb && dir == SHIFT_UP) |=> (q[0] == $past(din)) && (q[TOP] == $past(q[TOP-1]))); // R3
  AST_DOWN_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (stb && dir == SHIFT_DOWN) |=> (q[TOP] == $past(din)) && (q[0] == $past(q[1]))); // R4
endmodule

// File: rtl/sp_latch_bank.sv
module sp_latch_bank #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             le,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_next
);
  assign q_next = le ? d : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end

  AST_LATCH_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    le |=> q == $past(d)); // R7
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !le |=> $stable(q)); // R8
endmodule

// File: rtl/sp_latched_driver.sv
module sp_latched_driver
  import sp_drv_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdata_in,
  input  logic              dir,
  input  logic              le,
  input  logic              oe,
  output logic              sdata_out,
  output logic [NUM_CH-1:0] chan_on
);
  localparam int LAST = NUM_CH - 1;

  logic              shift_stb;
  shift_dir_e        dir_e;
  logic [NUM_CH-1:0] sreg, sreg_nxt;
  logic [NUM_CH-1:0] lat, lat_nxt;

  assign dir_e = shift_dir_e'(dir);

  sp_edge_strobe u_edge (
    .clk      (clk),
    .rst      (rst),
    .level_in (sclk),
    .fall_stb (shift_stb)
  );

  sp_shift_chain #(.DEPTH(NUM_CH)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .stb    (shift_stb),
    .dir    (dir_e),
    .din    (sdata_in),
    .q      (sreg),
    .q_next (sreg_nxt)
  );

  sp_latch_bank #(.WIDTH(NUM_CH)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .le     (le),
    .d      (sreg),
    .q      (lat),
    .q_next (lat_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sdata_out <= 1'b0;
      chan_on   <= '0;
    end else begin
      sdata_out <= (dir_e == SHIFT_UP) ? sreg_nxt[LAST] : sreg_nxt[0];
      chan_on   <= oe ? lat_nxt : '0;
    end
  end

  AST_CASCADE_END: assert property (@(posedge clk) disable iff (rst)
    sdata_out == ($past(dir) ? sreg[LAST] : sreg[0])); // R5
  AST_OE_OFF: assert property (@(posedge clk) disable iff (rst)
    !oe |=> chan_on == '0); // R9
  AST_OE_PASS: assert property (@(posedge clk) disable iff (rst)
    (oe && !le) |=> chan_on == lat); // R10
endmodule

// File: tb/test_sp_latched_driver.sv
`timescale 1ns/1ps
module test_sp_latched_driver;
  localparam int BN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdata_in = 1'b0, dir = 1'b1, le = 1'b0, oe = 1'b1;
  logic          sdata_out;
  logic [BN-1:0] chan_on;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [BN-1:0] model = '0;

  always #2 clk = ~clk;

  sp_latched_driver #(.NUM_CH(BN)) i_sp_latched_driver (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata_in(sdata_in), .dir(dir),
    .le(le), .oe(oe), .sdata_out(sdata_out), .chan_on(chan_on)
  );

  task automatic check(input string req, input logic [BN-1:0] act, input logic [BN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); sclk = 1'b1; sdata_in = b;
    @(negedge clk); sclk = 1'b0;
    @(negedge clk);
    if (dir) model = {model[BN-2:0], b};
    else     model = {b, model[BN-1:1]};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 chan_on after reset", chan_on, '0);
    check("R1 sdata_out after reset", {{(BN-1){1'b0}}, sdata_out}, '0);

    // transparent latch while shifting: chan_on tracks chain one edge after each shift
    dir = 1'b1; le = 1'b1; oe = 1'b1;
    for (int k = 0; k < BN; k++) begin
      shift_bit(((8'hA5 >> k) & 1) != 0);
      check("R6 cascade during transparent shift", {{(BN-1){1'b0}}, sdata_out}, {{(BN-1){1'b0}}, model[BN-1]});
      @(negedge clk);
      check("R7 latch follows chain", chan_on, model);
    end

    // rising sclk and steady high must not shift
    @(negedge clk); sclk = 1'b1; sdata_in = ~model[0];
    repeat (4) @(negedge clk);
    check("R2 no shift on rise/steady high", chan_on, model);
    sclk = 1'b0;
    @(negedge clk);
    model = {model[BN-2:0], sdata_in};
    @(negedge clk);
    check("R2 shift on fall", chan_on, model);

    // mid-run reset
    rst = 1'b1; @(negedge clk); rst = 1'b0; model = '0;
    check("R1 chan_on after mid reset", chan_on, '0);
    check("R1 sdata_out after mid reset", {{(BN-1){1'b0}}, sdata_out}, '0);
    le = 1'b0; oe = 1'b1;
    @(negedge clk);
    check("R1 latches cleared", chan_on, '0);

    // exhaustive pattern sweep in both directions
    for (int d = 1; d >= 0; d--) begin
      for (int p = 0; p < (1 << BN); p++) begin
        logic [BN-1:0] pat, prev;
        pat = p[BN-1:0];
        prev = chan_on;
        dir = d[0]; le = 1'b0; oe = 1'b1;
        for (int k = 0; k < BN; k++) begin
          int idx;
          idx = d[0] ? (BN-1-k) : k;
          shift_bit(pat[idx]);
          if (d[0]) check("R3 cascade from top stage", {{(BN-1){1'b0}}, sdata_out}, {{(BN-1){1'b0}}, model[BN-1]});
          else      check("R4 cascade from stage 0", {{(BN-1){1'b0}}, sdata_out}, {{(BN-1){1'b0}}, model[0]});
        end
        check("R8 latch holds during load", chan_on, prev);
        oe = 1'b0; le = 1'b1;
        @(negedge clk);
        check("R9 outputs off while oe low", chan_on, '0);
        le = 1'b0;
        @(negedge clk);
        oe = 1'b1;
        @(negedge clk);
        if (d[0]) check("R3 pattern via latch", chan_on, pat);
        else      check("R4 pattern via latch", chan_on, pat);
        check("R10 latched bits reach channels", chan_on, model);
        dir = ~d[0];
        @(negedge clk);
        check("R5 cascade follows dir change", {{(BN-1){1'b0}}, sdata_out},
              {{(BN-1){1'b0}}, (d[0] ? pat[0] : pat[BN-1])});
        dir = d[0];
        @(negedge clk);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule